// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block derives the serial clocks of a two-channel audio link from one source clock. A linear divider field, an odd-adjust bit and a master-clock-output enable set an effective division factor N = 2·DIV + ODD. The divided clock either becomes the master clock, which is then divided further into the bit clock, or it is used directly as the bit clock. A word-select output marks the left and right channel slots. A channel-side output reports which channel's bits are being clocked.

Configuration inputs are sampled only while `enable_i` is low. A running link therefore never sees a half-applied setting. While disabled, all clocks rest at their idle level. The bit clock idles at the selected polarity level. Divider values below two are replaced by the safe default DIV = 2, ODD = 0.

Top module: `audio_clk_prescaler`

## Requirements
- R1: A `div_i` value of 0 or 1 is replaced by DIV = 2 with ODD = 0. The resulting divider period is therefore 4 source cycles, whatever `odd_i` is.
- R2: The divided clock has a period of 2·DIV + ODD source cycles. Its high phase lasts DIV + ODD cycles and its low phase lasts DIV cycles.
- R3: With `mclk_en_i` = 1, `mclk_o` carries the divided clock. The bit clock is `mclk_o` divided by 8 when `wide_i` = 0 (16-bit channels), or by 4 when `wide_i` = 1 (32-bit channels).
- R4: With `mclk_en_i` = 0, `mclk_o` stays low and the bit clock runs at the divided clock itself.
- R5: `ws_o` starts at 0 (left channel) and toggles once every 16 bit-clock periods (`wide_i` = 0) or 32 periods (`wide_i` = 1). With the master clock enabled, one full frame therefore spans 256 master-clock periods.
- R6: `ws_o` changes only in the cycle where the bit clock leaves its active (non-idle) level.
- R7: While `enable_i` is low, `mclk_o` = 0, `ws_o` = 0, `chan_side_o` = 0 and `bclk_o` equals the latched `cpol_i`. With `cpol_i` = 1 the bit clock is inverted, so its active phase is its low phase.
- R8: Changes to `div_i`, `odd_i`, `mclk_en_i`, `wide_i` and `cpol_i` while `enable_i` is high have no effect. They take effect after the next disable.
- R9: `chan_side_o` takes the value of `ws_o` at the next rising of the active bit-clock phase. It therefore lags a word-select change by the rest of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the clocks; config is sampled while low |
| div_i | input | 8 | Linear divider DIV |
| odd_i | input | 1 | Odd-adjust bit added to 2·DIV |
| mclk_en_i | input | 1 | Route divided clock to master clock output |
| wide_i | input | 1 | 0: 16-bit channels, 1: 32-bit channels |
| cpol_i | input | 1 | Bit-clock idle level |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| chan_side_o | output | 1 | Channel whose bits are in progress |

## Verification
The bench measures high phase and full period on odd divisors, where a design that splits the phases wrongly would give unequal halves off by more than one or a period of 2·DIV. It loads the illegal values 0 and 1, which a design without the clamp would turn into a stuck or one-cycle clock. It also rewrites the configuration mid-run, which a design without the enable gate would take up at once. Word-select period is checked for both channel widths with and without the master clock, since a swapped further divider shows up as a frame of 128 or 512 master clocks. The bench also checks the bit-clock phase at each word-select change, the inverted polarity, and the half-bit lag of the channel-side output.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int unsigned DIV_W = 8;
  localparam logic [DIV_W-1:0] DIV_SAFE = DIV_W'(2);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mclk_en;
    logic             wide;
    logic             cpol;
  } acp_cfg_t;
endpackage

// File: rtl/acp_cfg_latch.sv
module acp_cfg_latch
  import acp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             wide_i,
  input  logic             cpol_i,
  output acp_cfg_t         cfg_o
);
  acp_cfg_t cfg_q;
  logic     legal;

  assign legal = (div_i >= DIV_SAFE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{div: DIV_SAFE, odd: 1'b0, mclk_en: 1'b0, wide: 1'b0, cpol: 1'b0};
    end else if (!enable_i) begin
      cfg_q.div     <= legal ? div_i : DIV_SAFE;
      cfg_q.odd     <= legal & odd_i;
      cfg_q.mclk_en <= mclk_en_i;
      cfg_q.wide    <= wide_i;
      cfg_q.cpol    <= cpol_i;
    end
  end

  assign cfg_o = cfg_q;

  p_div_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.div >= DIV_SAFE);

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_i) |-> cfg_q == $past(cfg_q));
endmodule

// File: rtl/acp_frac_div.sv
module acp_frac_div
  import acp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  output logic             pre_o,
  output logic             tgl_o
);
  logic [DIV_W-1:0] ph_q;
  logic             pre_q;
  logic [DIV_W:0]   hi_len;
  logic [DIV_W:0]   hi_m1;
  logic [DIV_W-1:0] lo_m1;

  // high phase carries the extra odd cycle
  assign hi_len = {1'b0, div_i} + {{DIV_W{1'b0}}, odd_i};
  assign hi_m1  = hi_len - (DIV_W+1)'(1);
  assign lo_m1  = div_i - DIV_W'(1);
  assign tgl_o  = run_i && (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= 1'b0;
      ph_q  <= '0;
    end else if (!run_i) begin
      pre_q <= 1'b0;
      ph_q  <= '0;
    end else if (ph_q == '0) begin
      pre_q <= ~pre_q;
      ph_q  <= pre_q ? lo_m1 : hi_m1[DIV_W-1:0];
    end else begin
      ph_q  <= ph_q - DIV_W'(1);
    end
  end

  assign pre_o = pre_q;

  p_phase_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ph_q} < hi_len);
endmodule

// File: rtl/acp_bclk_gen.sv
module acp_bclk_gen #(
  parameter int unsigned SUB_NARROW = 8,
  parameter int unsigned SUB_WIDE   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mclk_en_i,
  input  logic wide_i,
  input  logic pre_i,
  input  logic tgl_i,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned SUB_MAX = (SUB_NARROW > SUB_WIDE) ? SUB_NARROW : SUB_WIDE;
  localparam int unsigned SUB_W   = (SUB_MAX > 2) ? $clog2(SUB_MAX) : 1;

  logic [SUB_W-1:0] s_q;
  logic [SUB_W-1:0] s_last;
  logic [SUB_W-1:0] s_half;
  logic             pre_rise;
  logic             edge_ev;
  logic             bclk_q;

  assign s_last   = wide_i ? SUB_W'(SUB_WIDE - 1) : SUB_W'(SUB_NARROW - 1);
  assign s_half   = wide_i ? SUB_W'(SUB_WIDE / 2) : SUB_W'(SUB_NARROW / 2);
  assign pre_rise = tgl_i && !pre_i;
  assign edge_ev  = run_i && (mclk_en_i ? (pre_rise && (s_q == '0 || s_q == s_half))
                                        : tgl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      s_q    <= '0;
      bclk_q <= 1'b0;
    end else begin
      if (edge_ev) bclk_q <= ~bclk_q;
      if (mclk_en_i && pre_rise) s_q <= (s_q == s_last) ? '0 : s_q + SUB_W'(1);
    end
  end

  assign bclk_o = bclk_q;
  assign rise_o = edge_ev && !bclk_q;
  assign fall_o = edge_ev && bclk_q;

  p_sub_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q <= s_last);

  p_direct_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i && !mclk_en_i) |-> bclk_q == pre_i);
endmodule

// File: rtl/acp_ws_gen.sv
module acp_ws_gen #(
  parameter int unsigned CH_LEN_NARROW = 16,
  parameter int unsigned CH_LEN_WIDE   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wide_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic ws_o,
  output logic side_o
);
  localparam int unsigned B_W = $clog2(CH_LEN_WIDE);

  logic [B_W-1:0] b_q;
  logic [B_W-1:0] b_last;
  logic           ws_q;
  logic           side_q;

  assign b_last = wide_i ? B_W'(CH_LEN_WIDE - 1) : B_W'(CH_LEN_NARROW - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q    <= '0;
      ws_q   <= 1'b0;
      side_q <= 1'b0;
    end else if (!run_i) begin
      b_q    <= '0;
      ws_q   <= 1'b0;
      side_q <= 1'b0;
    end else begin
      if (fall_i) begin
        if (b_q == b_last) begin
          b_q  <= '0;
          ws_q <= ~ws_q;
        end else begin
          b_q  <= b_q + B_W'(1);
        end
      end
      if (rise_i) side_q <= ws_q;
    end
  end

  assign ws_o   = ws_q;
  assign side_o = side_q;

  p_ws_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && ws_q != $past(ws_q)) |-> $past(fall_i));

  p_side_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && side_q != $past(side_q)) |-> $past(rise_i));

  p_bit_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_q <= b_last);
endmodule

// File: rtl/audio_clk_prescaler.sv
module audio_clk_prescaler
  import acp_pkg::*;
#(
  parameter int unsigned MCLK_PER_FRAME = 256,
  parameter int unsigned CH_LEN_NARROW  = 16,
  parameter int unsigned CH_LEN_WIDE    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic [7:0] div_i,
  input  logic       odd_i,
  input  logic       mclk_en_i,
  input  logic       wide_i,
  input  logic       cpol_i,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       chan_side_o
);
  localparam int unsigned SUB_NARROW = MCLK_PER_FRAME / (2 * CH_LEN_NARROW);
  localparam int unsigned SUB_WIDE   = MCLK_PER_FRAME / (2 * CH_LEN_WIDE);

  acp_cfg_t cfg;
  logic     pre, tgl, bclk_int, b_rise, b_fall, ws_int, side_int;

  acp_cfg_latch u_cfg (
    .clk_i, .rst_ni, .enable_i,
    .div_i(div_i[DIV_W-1:0]), .odd_i, .mclk_en_i, .wide_i, .cpol_i,
    .cfg_o(cfg)
  );

  acp_frac_div u_div (
    .clk_i, .rst_ni, .run_i(enable_i),
    .div_i(cfg.div), .odd_i(cfg.odd),
    .pre_o(pre), .tgl_o(tgl)
  );

  acp_bclk_gen #(.SUB_NARROW(SUB_NARROW), .SUB_WIDE(SUB_WIDE)) u_bclk (
    .clk_i, .rst_ni, .run_i(enable_i),
    .mclk_en_i(cfg.mclk_en), .wide_i(cfg.wide),
    .pre_i(pre), .tgl_i(tgl),
    .bclk_o(bclk_int), .rise_o(b_rise), .fall_o(b_fall)
  );

  acp_ws_gen #(.CH_LEN_NARROW(CH_LEN_NARROW), .CH_LEN_WIDE(CH_LEN_WIDE)) u_ws (
    .clk_i, .rst_ni, .run_i(enable_i), .wide_i(cfg.wide),
    .rise_i(b_rise), .fall_i(b_fall),
    .ws_o(ws_int), .side_o(side_int)
  );

  assign mclk_o      = pre & cfg.mclk_en;
  assign bclk_o      = bclk_int ^ cfg.cpol;
  assign ws_o        = ws_int;
  assign chan_side_o = side_int;

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> (!mclk_o && !ws_o && !chan_side_o && bclk_o == $past(cpol_i)));

  p_ws_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && ws_o != $past(ws_o)) |-> (bclk_o == cfg.cpol));
endmodule

// File: tb/audio_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module audio_clk_prescaler_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       odd_i = 1'b0;
  logic       mclk_en_i = 1'b0;
  logic       wide_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic       mclk_o, bclk_o, ws_o, chan_side_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  audio_clk_prescaler dut_i (
    .clk_i, .rst_ni, .enable_i, .div_i, .odd_i, .mclk_en_i, .wide_i, .cpol_i,
    .mclk_o, .bclk_o, .ws_o, .chan_side_o
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic get_sig(input int sel);
    case (sel)
      0: return mclk_o;
      1: return bclk_o;
      2: return ws_o;
      default: return ~bclk_o;
    endcase
  endfunction

  task automatic measure(input int sel, output int per, output int hi);
    int n = 0;
    per = 0;
    hi = 0;
    while (get_sig(sel) !== 1'b0 && n < 20000) begin @(negedge clk_i); n++; end
    while (get_sig(sel) !== 1'b1 && n < 20000) begin @(negedge clk_i); n++; end
    while (get_sig(sel) === 1'b1 && hi < 20000) begin @(negedge clk_i); hi++; end
    per = hi;
    while (get_sig(sel) === 1'b0 && per < 40000) begin @(negedge clk_i); per++; end
  endtask

  task automatic start(input int d, input bit o, input bit m, input bit w, input bit c);
    @(negedge clk_i);
    enable_i = 1'b0;
    div_i = d[7:0]; odd_i = o; mclk_en_i = m; wide_i = w; cpol_i = c;
    repeat (3) @(negedge clk_i);
    enable_i = 1'b1;
  endtask

  task automatic t_reset_idle();
    check("R7 reset mclk", int'(mclk_o), 0);
    check("R7 reset bclk", int'(bclk_o), 0);
    check("R7 reset ws", int'(ws_o), 0);
    check("R7 reset side", int'(chan_side_o), 0);
  endtask

  task automatic t_clamp_r1();
    int p, h;
    start(0, 1'b0, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R1 div0 period", p, 4);
    check("R1 div0 high", h, 2);
    start(1, 1'b1, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R1 div1 odd period", p, 4);
  endtask

  task automatic t_ratio_r2();
    int p, h;
    start(5, 1'b0, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R2 div5 period", p, 10);
    check("R2 div5 high", h, 5);
    start(3, 1'b1, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R2 div3 odd period", p, 7);
    check("R2 div3 odd high", h, 4);
    start(255, 1'b1, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R2 div255 odd period", p, 511);
    check("R2 div255 odd high", h, 256);
  endtask

  task automatic t_mclk_r3();
    int p, h;
    start(3, 1'b1, 1'b1, 1'b0, 1'b0);
    measure(0, p, h);
    check("R3 mclk period", p, 7);
    check("R3 mclk high", h, 4);
    measure(1, p, h);
    check("R3 bclk narrow period", p, 56);
    check("R3 bclk narrow high", h, 28);
    start(3, 1'b1, 1'b1, 1'b1, 1'b0);
    measure(1, p, h);
    check("R3 bclk wide period", p, 28);
    check("R3 bclk wide high", h, 14);
  endtask

  task automatic t_direct_r4();
    int p, h, seen;
    start(2, 1'b0, 1'b0, 1'b0, 1'b0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (mclk_o !== 1'b0) seen++;
    end
    check("R4 mclk quiet", seen, 0);
    measure(1, p, h);
    check("R4 bclk direct period", p, 4);
  endtask

  task automatic t_ws_r5();
    int p, h;
    start(2, 1'b0, 1'b0, 1'b0, 1'b0);
    measure(2, p, h);
    check("R5 ws direct narrow period", p, 128);
    check("R5 ws direct narrow high", h, 64);
    start(2, 1'b0, 1'b0, 1'b1, 1'b0);
    measure(2, p, h);
    check("R5 ws direct wide period", p, 256);
    start(2, 1'b0, 1'b1, 1'b0, 1'b0);
    measure(2, p, h);
    check("R5 ws mclk narrow period", p, 1024);
    start(2, 1'b0, 1'b1, 1'b1, 1'b0);
    measure(2, p, h);
    check("R5 ws mclk wide period", p, 1024);
  endtask

  task automatic t_ws_edge_r6();
    logic pb, pw;
    int hits = 0, bad = 0;
    start(3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    pb = bclk_o; pw = ws_o;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk_i);
      if (ws_o !== pw) begin
        hits++;
        if (!(pb === 1'b1 && bclk_o === 1'b0)) bad++;
      end
      pb = bclk_o; pw = ws_o;
    end
    check("R6 ws changes seen", int'(hits > 0), 1);
    check("R6 ws on bclk fall", bad, 0);
  endtask

  task automatic t_cpol_r7();
    int p, h;
    @(negedge clk_i);
    enable_i = 1'b0; cpol_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R7 idle bclk high", int'(bclk_o), 1);
    check("R7 idle ws", int'(ws_o), 0);
    check("R7 idle mclk", int'(mclk_o), 0);
    start(3, 1'b1, 1'b0, 1'b0, 1'b1);
    measure(3, p, h);
    check("R7 inverted active phase", h, 4);
    measure(1, p, h);
    check("R7 inverted period", p, 7);
    check("R7 inverted idle phase", h, 3);
  endtask

  task automatic t_hold_r8();
    int p, h, seen;
    start(2, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    div_i = 8'd9; odd_i = 1'b1; mclk_en_i = 1'b1; cpol_i = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (mclk_o !== 1'b0) seen++;
    end
    check("R8 mclk still off", seen, 0);
    measure(1, p, h);
    check("R8 period unchanged", p, 4);
    check("R8 polarity unchanged", h, 2);
    start(9, 1'b1, 1'b0, 1'b0, 1'b0);
    measure(1, p, h);
    check("R8 new value after disable", p, 19);
  endtask

  task automatic t_side_r9();
    logic pw;
    int n = 0;
    start(2, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    pw = ws_o;
    while (!(pw === 1'b0 && ws_o === 1'b1) && n < 2000) begin
      pw = ws_o; @(negedge clk_i); n++;
    end
    check("R9 side lags ws", int'(chan_side_o), 0);
    while (bclk_o !== 1'b1 && n < 2000) begin @(negedge clk_i); n++; end
    check("R9 side at next bclk rise", int'(chan_side_o), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset_idle();
    t_clamp_r1();
    t_ratio_r2();
    t_mclk_r3();
    t_direct_r4();
    t_ws_r5();
    t_ws_edge_r6();
    t_cpol_r7();
    t_hold_r8();
    t_side_r9();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule